// File: doc/BRIEF.md
# Timer Event Status Flags

This block is a small up-counting timer with one channel that can either compare the counter against a programmed value or capture the counter on an input edge. Around it sits a 16-bit status register. The register records six kinds of event: counter wrap, channel event, control-update (COM) event, trigger edge, break level and channel overcapture. Hardware sets each flag, and software clears it by writing a zero to its bit. A register interrupt output signals when any flag that software has enabled is set.

A simple synchronous register bus reaches three locations. Address 0 is the status register, which can be read and written. Address 1 is the interrupt enable register, which can be read and written and has the same bit layout as the status register. Address 2 is the capture register, which is read-only and zero-extended. Read data appears on `bus_rdata` one clock after the read strobe. The counter limit, the compare value and the channel mode arrive as static configuration ports.

Top module: `tmr_evt_status`

## Requirements
- R1: After synchronous reset, the status, interrupt enable and capture registers all read 0, `bus_rdata` is 0 and `irq` is 0.
- R2: The status flags sit at these bit positions: bit 0 is wrap, bit 1 is channel, bit 5 is COM, bit 6 is trigger, bit 7 is break and bit 9 is overcapture. Every other status bit reads 0. Reads return data one cycle after a strobe with `bus_wr`=0, from address 0 (status), 1 (enable) or 2 (capture).
- R3: A write to address 0 clears each flag whose data bit is 0. A flag whose data bit is 1 keeps its value.
- R4: If a hardware set and a software clear reach the same flag in the same cycle, the flag is set afterwards.
- R5: The break flag (bit 7) is set in every cycle in which `brk_in` is 1. A clear of it takes effect only while `brk_in` is 0.
- R6: When `trg_gated`=0, the trigger flag (bit 6) sets on a rising edge of `trg_in` and ignores falling edges. When `trg_gated`=1, it sets on both edges.
- R7: A one-cycle pulse on `com_evt` sets the COM flag (bit 5).
- R8: When `cnt_en`=1, the counter steps up by one. From `reload_val` it goes to 0, and that wrap sets the wrap flag (bit 0).
- R9: When `cc_capture`=0, the channel flag (bit 1) sets while the enabled counter equals `cmp_val`. If `cmp_val` exceeds `reload_val`, the flag sets at the wrap instead.
- R10: When `cc_capture`=1, `cap_in` passes through two synchronizer flops. An edge of the selected polarity (`cap_falling`=0 means rising, 1 means falling) copies the counter into the capture register and sets bit 1. Edges of the other polarity do nothing. A bus read of address 2 clears bit 1.
- R11: When `cc_capture`=1, a capture that arrives while bit 1 is already set also sets the overcapture flag (bit 9).
- R12: `irq` is 1 one cycle after any flag is set whose enable bit (address 1, same layout) is also set. A flag whose enable bit is 0 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter enable |
| reload_val | input | CNT_W | Counter top value before wrap |
| cmp_val | input | CNT_W | Compare value for the channel |
| cc_capture | input | 1 | Channel mode: 1 capture, 0 compare |
| cap_falling | input | 1 | Capture polarity: 1 falling, 0 rising |
| cap_in | input | 1 | Asynchronous capture input |
| brk_in | input | 1 | Break level, active high |
| trg_in | input | 1 | Synchronous trigger input |
| trg_gated | input | 1 | Trigger on both edges when 1 |
| com_evt | input | 1 | Control-update event pulse |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with `CNT_W`=8. This keeps the wrap and the compare-above-limit case within a dozen counted cycles, so both R8 and R9 can be observed against an exactly predicted counter value. The capture tests freeze the counter at a known count by gating `cnt_en`, so the captured value is fixed regardless of the synchronizer latency. The bench then drives repeated edges of both polarities to reach overcapture and the read-to-clear path.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned B_WRAP = 0;
  localparam int unsigned B_CHAN = 1;
  localparam int unsigned B_COM  = 5;
  localparam int unsigned B_TRG  = 6;
  localparam int unsigned B_BRK  = 7;
  localparam int unsigned B_OVR  = 9;
  localparam logic [REG_W-1:0] STS_MASK = 16'h02E3;
  localparam logic [1:0] A_STS = 2'd0;
  localparam logic [1:0] A_IEN = 2'd1;
  localparam logic [1:0] A_CAP = 2'd2;
endpackage

// File: rtl/tmr_upcnt.sv
module tmr_upcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = en && (cnt == reload);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end

  // R8: the counter returns to zero after a wrap
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == reload) |=> (cnt == '0));
endmodule

// File: rtl/tmr_cc1.sv
module tmr_cc1 #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_mode,
  input  logic             cap_falling,
  input  logic             cap_in,
  input  logic             cnt_en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] ccr,
  output logic             cap_evt,
  output logic             chan_evt
);
  localparam int unsigned CHAIN = SYNC_N + 1;

  logic [CHAIN-1:0] sh;
  logic             cur, prv;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[CHAIN-2:0], cap_in};
  end

  assign cur = sh[CHAIN-2];
  assign prv = sh[CHAIN-1];
  assign cap_evt = cap_mode && (cap_falling ? (prv && !cur) : (!prv && cur));

  always_ff @(posedge clk) begin
    if (rst)          ccr <= '0;
    else if (cap_evt) ccr <= cnt;
  end

  always_comb begin
    if (cap_mode)          chan_evt = cap_evt;
    else if (cmp > reload) chan_evt = wrap;
    else                   chan_evt = cnt_en && (cnt == cmp);
  end

  // R10: a capture loads the counter value
  p_capture_loads_r10: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !rst) |=> (ccr == $past(cnt)));
endmodule

// File: rtl/tmr_stsreg.sv
module tmr_stsreg
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_wrap,
  input  logic             ev_chan,
  input  logic             ev_cap,
  input  logic             cap_mode,
  input  logic             ev_com,
  input  logic             ev_trg,
  input  logic             brk_lvl,
  input  logic             sw_wr,
  input  logic [REG_W-1:0] sw_data,
  input  logic             rd_cap,
  output logic [REG_W-1:0] sts
);
  logic [REG_W-1:0] hw_set, clr, nxt;

  always_comb begin
    hw_set         = '0;
    hw_set[B_WRAP] = ev_wrap;
    hw_set[B_CHAN] = ev_chan;
    hw_set[B_COM]  = ev_com;
    hw_set[B_TRG]  = ev_trg;
    hw_set[B_BRK]  = brk_lvl;
    hw_set[B_OVR]  = cap_mode && ev_cap && sts[B_CHAN];

    clr = sw_wr ? ~sw_data : '0;
    if (brk_lvl) clr[B_BRK] = 1'b0;
    if (rd_cap)  clr[B_CHAN] = 1'b1;

    nxt = (hw_set | (sts & ~clr)) & STS_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= nxt;
  end

  // R4: every hardware set lands, whatever software does in that cycle
  p_hw_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && |(hw_set & STS_MASK)) |=> ((sts & $past(hw_set & STS_MASK)) == $past(hw_set & STS_MASK)));
  // R5: break flag held while break is active
  p_brk_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && brk_lvl) |=> sts[B_BRK]);
  // R7: COM pulse sets its flag
  p_com_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && ev_com) |=> sts[B_COM]);
  // R11: overcapture only rises when the channel flag was already set
  p_ovr_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[B_OVR]) |-> $past(sts[B_CHAN]));
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cc_capture,
  input  logic             cap_falling,
  input  logic             cap_in,
  input  logic             brk_in,
  input  logic             trg_in,
  input  logic             trg_gated,
  input  logic             com_evt,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             irq
);
  logic [CNT_W-1:0] cnt, ccr;
  logic             wrap, cap_evt, chan_evt;
  logic             trg_q, trg_evt;
  logic [REG_W-1:0] sts, ien, ccr_ext;
  logic             sts_wr, ien_wr, rd_any, rd_cap;

  tmr_upcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .reload(reload_val),
    .cnt(cnt), .wrap(wrap)
  );

  tmr_cc1 #(.CNT_W(CNT_W), .SYNC_N(2)) u_cc (
    .clk(clk), .rst(rst), .cap_mode(cc_capture), .cap_falling(cap_falling),
    .cap_in(cap_in), .cnt_en(cnt_en), .wrap(wrap), .cnt(cnt), .cmp(cmp_val),
    .reload(reload_val), .ccr(ccr), .cap_evt(cap_evt), .chan_evt(chan_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) trg_q <= 1'b0;
    else     trg_q <= trg_in;
  end
  assign trg_evt = trg_gated ? (trg_in != trg_q) : (trg_in && !trg_q);

  assign sts_wr = bus_sel && bus_wr && (bus_addr == A_STS);
  assign ien_wr = bus_sel && bus_wr && (bus_addr == A_IEN);
  assign rd_any = bus_sel && !bus_wr;
  assign rd_cap = rd_any && (bus_addr == A_CAP) && cc_capture;

  tmr_stsreg u_sts (
    .clk(clk), .rst(rst), .ev_wrap(wrap), .ev_chan(chan_evt), .ev_cap(cap_evt),
    .cap_mode(cc_capture), .ev_com(com_evt), .ev_trg(trg_evt), .brk_lvl(brk_in),
    .sw_wr(sts_wr), .sw_data(bus_wdata), .rd_cap(rd_cap), .sts(sts)
  );

  always_comb begin
    ccr_ext = '0;
    ccr_ext[CNT_W-1:0] = ccr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (ien_wr) ien <= bus_wdata & STS_MASK;
      if (rd_any) begin
        case (bus_addr)
          A_STS:   bus_rdata <= sts;
          A_IEN:   bus_rdata <= ien;
          A_CAP:   bus_rdata <= ccr_ext;
          default: bus_rdata <= '0;
        endcase
      end
      irq <= |(sts & ien);
    end
  end

  // R2: reserved status bits never appear on a status read
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && rd_any && bus_addr == A_STS) |=> ((bus_rdata & ~STS_MASK) == '0));
endmodule

// File: tb/sim_tmr_evt_status.sv
module sim_tmr_evt_status;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst = 1;
  logic cnt_en = 0, cc_capture = 0, cap_falling = 0, cap_in = 0;
  logic brk_in = 0, trg_in = 0, trg_gated = 0, com_evt = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [W-1:0] reload_val = 8'd200, cmp_val = 8'd250;
  logic [15:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [15:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_status #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .reload_val(reload_val), .cmp_val(cmp_val),
    .cc_capture(cc_capture), .cap_falling(cap_falling), .cap_in(cap_in),
    .brk_in(brk_in), .trg_in(trg_in), .trg_gated(trg_gated), .com_evt(com_evt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // {com, trg, brk, wr, wdata[15:0], expected status[15:0]}
  localparam logic [35:0] VEC [9] = '{
    {4'b1000, 16'h0000, 16'h0020},  // R7 COM pulse
    {4'b0100, 16'h0000, 16'h0060},  // R6 rising trigger
    {4'b0001, 16'hFFDF, 16'h0040},  // R3 clear COM only
    {4'b0010, 16'h0000, 16'h00C0},  // R5 break sets
    {4'b0011, 16'h0000, 16'h0080},  // R5 clear blocked by active break
    {4'b0001, 16'h0000, 16'h0000},  // R5 clear after break released
    {4'b0001, 16'hFFFF, 16'h0000},  // R3 writing ones changes nothing
    {4'b1001, 16'h0000, 16'h0020},  // R4 set beats clear
    {4'b0001, 16'hFFDF, 16'h0000}   // R3 clear
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic do_reset();
    rst = 1; cnt_en = 0; cap_in = 0; brk_in = 0; trg_in = 0; com_evt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    chk("R1 rdata", bus_rdata, 16'h0000);
    bus_read(2'd0, rd); chk("R1 status", rd, 16'h0000);
    bus_read(2'd1, rd); chk("R1 enable", rd, 16'h0000);
    bus_read(2'd2, rd); chk("R1 capture", rd, 16'h0000);

    // vector table (counter idle)
    for (int i = 0; i < 9; i++) begin
      com_evt = VEC[i][35]; trg_in = VEC[i][34]; brk_in = VEC[i][33];
      if (VEC[i][32]) begin bus_sel = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = VEC[i][31:16]; end
      @(negedge clk);
      com_evt = 0; trg_in = 0; brk_in = 0; bus_sel = 0; bus_wr = 0;
      bus_read(2'd0, rd);
      chk($sformatf("R2 vector %0d", i), rd, VEC[i][15:0]);
    end

    // R6 gated mode: both edges
    trg_gated = 1; trg_in = 1; @(negedge clk);
    bus_read(2'd0, rd); chk("R6 gated rise", rd, 16'h0040);
    bus_write(2'd0, 16'h0000);
    trg_in = 0; @(negedge clk);
    bus_read(2'd0, rd); chk("R6 gated fall", rd, 16'h0040);
    trg_gated = 0; bus_write(2'd0, 16'h0000);
    trg_in = 1; @(negedge clk);
    bus_write(2'd0, 16'h0000);
    trg_in = 0; @(negedge clk);
    bus_read(2'd0, rd); chk("R6 plain fall ignored", rd, 16'h0000);

    // R9 compare within range
    do_reset();
    reload_val = 8'd9; cmp_val = 8'd4; run(6);
    bus_read(2'd0, rd); chk("R9 compare match", rd, 16'h0002);

    // R9 compare above limit, R8 wrap
    do_reset();
    cmp_val = 8'd12; run(9);
    bus_read(2'd0, rd); chk("R9 no flag before wrap", rd, 16'h0000);
    run(3);
    bus_read(2'd0, rd); chk("R8 R9 wrap sets both", rd, 16'h0003);

    // R10 capture with counter frozen at 7
    do_reset();
    reload_val = 8'd200; cmp_val = 8'd250; cc_capture = 1; cap_falling = 0;
    run(7);
    cap_in = 1; repeat (4) @(negedge clk);
    bus_read(2'd0, rd); chk("R10 capture flag", rd, 16'h0002);
    bus_read(2'd2, rd); chk("R10 capture value", rd, 16'h0007);
    bus_read(2'd0, rd); chk("R10 read clears", rd, 16'h0000);
    cap_in = 0; repeat (4) @(negedge clk);
    bus_read(2'd0, rd); chk("R10 wrong polarity ignored", rd, 16'h0000);
    // R11 overcapture
    cap_in = 1; repeat (4) @(negedge clk);
    cap_in = 0; repeat (4) @(negedge clk);
    cap_in = 1; repeat (4) @(negedge clk);
    bus_read(2'd0, rd); chk("R11 overcapture", rd, 16'h0202);
    bus_read(2'd2, rd);
    bus_read(2'd0, rd); chk("R11 ovr survives read", rd, 16'h0200);
    // R10 falling polarity
    bus_write(2'd0, 16'h0000);
    cap_falling = 1; cap_in = 0; repeat (4) @(negedge clk);
    bus_read(2'd0, rd); chk("R10 falling capture", rd, 16'h0002);
    cc_capture = 0;

    // R12 interrupt
    do_reset();
    bus_write(2'd1, 16'h0020);
    bus_read(2'd1, rd); chk("R12 enable readback", rd, 16'h0020);
    chk("R12 idle irq", {15'd0, irq}, 16'h0000);
    com_evt = 1; @(negedge clk); com_evt = 0; @(negedge clk);
    chk("R12 irq raised", {15'd0, irq}, 16'h0001);
    bus_write(2'd1, 16'h0000); @(negedge clk);
    chk("R12 masked flag", {15'd0, irq}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule